// File: doc/BRIEF.md
# PHY Reset and Power Sequencer

This block owns the control bits of a high-speed serial PHY and runs its bring-up, low-power entry, low-power exit and cable-event updates in hardware. Request pulses on the input side start short ordered sequences. Each sequence writes one control bit per step and checks that bit one cycle later. The bring-up sequence holds the PHY reset asserted for a time set by the clock frequency and a minimum pulse width, both given as parameters.

Requests that arrive while a sequence is running are latched and run later, in a fixed priority order. Low-power entry and exit requests are dropped when the PHY is already in the requested state. Cable connect and disconnect events move the lane power-present bit only when the bus-power override mode is on and host mode is off. A combinational read port shows the control bits at fixed positions within small registers, together with a status word.

A strap input sets the reset value of the test-powerdown bit, so the PHY can be held powered down from power-up. Regulator and clock-gate handling sit outside the block. It offers `busy` and a one-cycle `done` to the logic that performs them.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rstN` is low at a clock edge, the block returns to idle. After that edge `busy`=0, `done`=0, `phyRst`=0, `pcsClkSel`=0, `lanePwrPresent`=0 and `refClkEn`=0, the sequence error flag is 0, and the PHY is marked suspended (status bit 1 = 1).
- R2: An init request asserts `phyRst`. It holds `phyRst` high for at least RST_CYCLES = CLK_MHZ*RESET_US cycles and for no more than RST_CYCLES+4 cycles, then releases it.
- R3: After `phyRst` is released, init sets `pcsClkSel`, then `lanePwrPresent`, then `refClkEn`, each in a later cycle than the one before. When init completes, the PHY is marked not suspended.
- R4: A suspend request on a resumed PHY clears `refClkEn` in a cycle strictly earlier than the one in which it sets `testPowerdown`. Afterwards the PHY is marked suspended.
- R5: A resume request on a suspended PHY sets `refClkEn` in a cycle strictly earlier than the one in which it clears `testPowerdown`. Afterwards the PHY is marked not suspended.
- R6: A suspend request while suspended, or a resume request while not suspended, is dropped. `busy` stays 0 and no control bit changes.
- R7: A connect event sets `lanePwrPresent` and a disconnect event clears it, but only while `vbusOverride`=1 and `hostMode`=0. In any other case the event is dropped and no bit changes.
- R8: `busy` goes high in the cycle after the edge that samples an accepted request, while the block is idle. It stays high until the last step completes. `done` pulses for one cycle in the last busy cycle. Control bits change only while busy. Requests that arrive while busy are held and run afterwards.
- R9: At most one control bit changes in any cycle. Each written bit is compared one cycle later with the value written. A mismatch sets a sticky error flag (status bit 2) that only reset clears.
- R10: Read port `regAddr` maps as follows: 0 holds `pcsClkSel` at bit 4; 1 holds `phyRst` at bit 7; 2 holds `refClkEn` at bit 0; 3 holds `lanePwrPresent` at bit 2 and `testPowerdown` at bit 4; 4 holds status (bit 0 busy, bit 1 suspended, bit 2 error). All other bits and addresses read 0.
- R11: Among held requests, the order of service is init, then suspend, then resume, then connect, then disconnect.
- R12: The reset value of `testPowerdown` equals the `keepPowerdown` strap. With the strap at 0 it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| keepPowerdown | input | 1 | Strap: reset value of test-powerdown |
| vbusOverride | input | 1 | Enables cable events to drive lane power-present |
| hostMode | input | 1 | Host mode; blocks cable-event updates |
| initReq | input | 1 | Bring-up request pulse |
| suspendReq | input | 1 | Low-power entry request pulse |
| resumeReq | input | 1 | Low-power exit request pulse |
| connectEvt | input | 1 | Cable connect event pulse |
| disconnectEvt | input | 1 | Cable disconnect event pulse |
| regAddr | input | 3 | Read port address |
| regRdData | output | 8 | Read port data (combinational) |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse on the last step |
| phyRst | output | 1 | PHY reset |
| pcsClkSel | output | 1 | PCS clock source select |
| lanePwrPresent | output | 1 | Lane power-present indication |
| refClkEn | output | 1 | Reference clock enable |
| testPowerdown | output | 1 | PHY test powerdown |

## Verification
The bound checker watches these rules on every cycle:
- the minimum reset pulse width, counted by a cycle counter;
- at most one control-bit change per cycle;
- the order of the bit edges during suspend and resume;
- `pcsClkSel` never rising while reset is held;
- control bits moving only while busy, and `done` ending a busy period;
- the stickiness of the error flag.

Other behaviour only the bench scenarios can show:
- dropping of redundant suspend and resume requests;
- gating of cable events by override and host mode;
- priority among requests held during a running init;
- the strap-dependent reset value;
- the read-port layout.

A seeded random walk over suspend, resume, connect and disconnect with random modes is compared against a bench model.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  localparam int REG_AW = 3;
  localparam int NREQ   = 5;

  // read-port layout
  localparam logic [REG_AW-1:0] ADDR_CLK  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_RST  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_REF  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_LANE = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_STAT = 3'd4;

  localparam int BIT_REFEN  = 0;
  localparam int BIT_LANE   = 2;
  localparam int BIT_CLKSEL = 4;
  localparam int BIT_PDN    = 4;
  localparam int BIT_RST    = 7;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_SUSP  = 1;
  localparam int STAT_ERR   = 2;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_RST, FLD_CLKSEL, FLD_LANE, FLD_REFEN, FLD_PDN
  } ctlField_e;

  // index order is service priority
  typedef enum logic [2:0] {
    SEQ_INIT = 3'd0, SEQ_SUSP = 3'd1, SEQ_RES = 3'd2, SEQ_CONN = 3'd3, SEQ_DISC = 3'd4
  } seqKind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_CHECK, ST_HOLD} seqState_e;

  typedef struct packed {
    logic      wr;
    ctlField_e field;
    logic      val;
    logic      chk;
  } dpStrobe_t;

  typedef struct packed {
    ctlField_e field;
    logic      val;
    logic      last;
  } stepInfo_t;

endpackage

// File: rtl/phy_pwr_ctl.sv
module phy_pwr_ctl
  import phy_pwr_pkg::*;
#(
  parameter int RST_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      vbusOverride,
  input  logic      hostMode,
  input  logic      initReq,
  input  logic      suspendReq,
  input  logic      resumeReq,
  input  logic      connectEvt,
  input  logic      disconnectEvt,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      suspended
);

  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] HOLD_LAST = CW'(RST_CYCLES - 1);

  seqState_e        state;
  seqKind_e         seqKind;
  seqKind_e         winner;
  logic [2:0]       stepIdx;
  logic [CW-1:0]    holdCnt;
  logic [NREQ-1:0]  reqIn, pend, eff, elig, cand, take;
  logic             found;
  stepInfo_t        cur;

  function automatic stepInfo_t mk(ctlField_e f, logic v, logic l);
    stepInfo_t s;
    s.field = f;
    s.val   = v;
    s.last  = l;
    return s;
  endfunction

  function automatic stepInfo_t stepOf(seqKind_e k, logic [2:0] idx);
    stepInfo_t s;
    s = mk(FLD_NONE, 1'b0, 1'b1);
    case (k)
      SEQ_INIT: case (idx)
        3'd0:    s = mk(FLD_RST,    1'b1, 1'b0);
        3'd1:    s = mk(FLD_RST,    1'b0, 1'b0);
        3'd2:    s = mk(FLD_CLKSEL, 1'b1, 1'b0);
        3'd3:    s = mk(FLD_LANE,   1'b1, 1'b0);
        default: s = mk(FLD_REFEN,  1'b1, 1'b1);
      endcase
      SEQ_SUSP: s = (idx == 3'd0) ? mk(FLD_REFEN, 1'b0, 1'b0) : mk(FLD_PDN, 1'b1, 1'b1);
      SEQ_RES:  s = (idx == 3'd0) ? mk(FLD_REFEN, 1'b1, 1'b0) : mk(FLD_PDN, 1'b0, 1'b1);
      SEQ_CONN: s = mk(FLD_LANE, 1'b1, 1'b1);
      SEQ_DISC: s = mk(FLD_LANE, 1'b0, 1'b1);
      default:  s = mk(FLD_NONE, 1'b0, 1'b1);
    endcase
    return s;
  endfunction

  assign reqIn = {disconnectEvt, connectEvt, resumeReq, suspendReq, initReq};
  assign eff   = pend | reqIn;

  // eligibility and priority pick
  always_comb begin
    elig           = '0;
    elig[SEQ_INIT] = 1'b1;
    elig[SEQ_SUSP] = !suspended;
    elig[SEQ_RES]  = suspended;
    elig[SEQ_CONN] = vbusOverride && !hostMode;
    elig[SEQ_DISC] = vbusOverride && !hostMode;
    cand   = eff & elig;
    take   = '0;
    winner = SEQ_INIT;
    found  = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (cand[i] && !found) begin
        take[i] = 1'b1;
        winner  = seqKind_e'(i[2:0]);
        found   = 1'b1;
      end
    end
  end

  assign cur  = stepOf(seqKind, stepIdx);
  assign busy = (state != ST_IDLE);
  assign done = (state == ST_CHECK) && cur.last;

  always_comb begin
    strobe.wr    = (state == ST_STEP);
    strobe.field = cur.field;
    strobe.val   = cur.val;
    strobe.chk   = (state == ST_CHECK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      seqKind   <= SEQ_INIT;
      stepIdx   <= '0;
      holdCnt   <= '0;
      pend      <= '0;
      suspended <= 1'b1;
    end else begin
      if (state == ST_IDLE) pend <= cand & ~take;
      else                  pend <= eff;
      case (state)
        ST_IDLE: if (found) begin
          seqKind <= winner;
          stepIdx <= '0;
          state   <= ST_STEP;
        end
        ST_STEP: state <= ST_CHECK;
        ST_CHECK: begin
          if (cur.last) begin
            state <= ST_IDLE;
            if (seqKind == SEQ_SUSP) suspended <= 1'b1;
            else if (seqKind == SEQ_RES || seqKind == SEQ_INIT) suspended <= 1'b0;
          end else if (seqKind == SEQ_INIT && stepIdx == 3'd0) begin
            holdCnt <= '0;
            state   <= ST_HOLD;
          end else begin
            stepIdx <= stepIdx + 3'd1;
            state   <= ST_STEP;
          end
        end
        ST_HOLD: begin
          holdCnt <= holdCnt + 1'b1;
          if (holdCnt == HOLD_LAST) begin
            stepIdx <= 3'd1;
            state   <= ST_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwr_dp.sv
module phy_pwr_dp
  import phy_pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              keepPowerdown,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              suspended,
  input  logic [REG_AW-1:0] regAddr,
  output logic [7:0]        regRdData,
  output logic              phyRst,
  output logic              pcsClkSel,
  output logic              lanePwr,
  output logic              refEn,
  output logic              testPdn,
  output logic              seqError
);

  ctlField_e chkField;
  logic      chkVal;
  logic      curVal;

  always_comb begin
    case (chkField)
      FLD_RST:    curVal = phyRst;
      FLD_CLKSEL: curVal = pcsClkSel;
      FLD_LANE:   curVal = lanePwr;
      FLD_REFEN:  curVal = refEn;
      FLD_PDN:    curVal = testPdn;
      default:    curVal = chkVal;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyRst    <= 1'b0;
      pcsClkSel <= 1'b0;
      lanePwr   <= 1'b0;
      refEn     <= 1'b0;
      testPdn   <= keepPowerdown;
      chkField  <= FLD_NONE;
      chkVal    <= 1'b0;
      seqError  <= 1'b0;
    end else begin
      if (strobe.wr) begin
        case (strobe.field)
          FLD_RST:    phyRst    <= strobe.val;
          FLD_CLKSEL: pcsClkSel <= strobe.val;
          FLD_LANE:   lanePwr   <= strobe.val;
          FLD_REFEN:  refEn     <= strobe.val;
          FLD_PDN:    testPdn   <= strobe.val;
          default: ;
        endcase
        chkField <= strobe.field;
        chkVal   <= strobe.val;
      end
      if (strobe.chk && (curVal != chkVal)) seqError <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CLK:  regRdData[BIT_CLKSEL] = pcsClkSel;
      ADDR_RST:  regRdData[BIT_RST]    = phyRst;
      ADDR_REF:  regRdData[BIT_REFEN]  = refEn;
      ADDR_LANE: begin
        regRdData[BIT_LANE] = lanePwr;
        regRdData[BIT_PDN]  = testPdn;
      end
      ADDR_STAT: begin
        regRdData[STAT_BUSY] = busy;
        regRdData[STAT_SUSP] = suspended;
        regRdData[STAT_ERR]  = seqError;
      end
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int RESET_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keepPowerdown,
  input  logic       vbusOverride,
  input  logic       hostMode,
  input  logic       initReq,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       connectEvt,
  input  logic       disconnectEvt,
  input  logic [2:0] regAddr,
  output logic [7:0] regRdData,
  output logic       busy,
  output logic       done,
  output logic       phyRst,
  output logic       pcsClkSel,
  output logic       lanePwrPresent,
  output logic       refClkEn,
  output logic       testPowerdown
);

  localparam int RST_CYCLES = CLK_MHZ * RESET_US;

  dpStrobe_t strobe;
  logic      suspended;
  logic      seqError;

  phy_pwr_ctl #(.RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .vbusOverride(vbusOverride), .hostMode(hostMode),
    .initReq(initReq), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .connectEvt(connectEvt), .disconnectEvt(disconnectEvt),
    .strobe(strobe), .busy(busy), .done(done), .suspended(suspended)
  );

  phy_pwr_dp u_dp (
    .clk(clk), .rstN(rstN), .keepPowerdown(keepPowerdown),
    .strobe(strobe), .busy(busy), .suspended(suspended),
    .regAddr(regAddr), .regRdData(regRdData),
    .phyRst(phyRst), .pcsClkSel(pcsClkSel), .lanePwr(lanePwrPresent),
    .refEn(refClkEn), .testPdn(testPowerdown), .seqError(seqError)
  );

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int RST_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic phyRst,
  input logic pcsClkSel,
  input logic lanePwrPresent,
  input logic refClkEn,
  input logic testPowerdown,
  input logic busy,
  input logic done,
  input logic seqError
);

  int rstHighCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       rstHighCnt <= 0;
    else if (phyRst) rstHighCnt <= rstHighCnt + 1;
    else             rstHighCnt <= 0;
  end

  assert_rst_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyRst) |-> (rstHighCnt >= RST_CYCLES));

  assert_clksel_after_rst_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pcsClkSel) |-> !phyRst);

  assert_suspend_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testPowerdown) |-> !refClkEn);

  assert_resume_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(testPowerdown) |-> refClkEn);

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_bits_move_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(phyRst) || !$stable(pcsClkSel) || !$stable(lanePwrPresent) ||
     !$stable(refClkEn) || !$stable(testPowerdown)) |-> $past(busy));

  assert_one_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!$stable(phyRst), !$stable(pcsClkSel), !$stable(lanePwrPresent),
                !$stable(refClkEn), !$stable(testPowerdown)}) <= 1);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError);

endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .phyRst(phyRst), .pcsClkSel(pcsClkSel),
  .lanePwrPresent(lanePwrPresent), .refClkEn(refClkEn),
  .testPowerdown(testPowerdown), .busy(busy), .done(done), .seqError(seqError)
);

// File: tb/phy_pwr_seq_tb.sv
module phy_pwr_seq_tb;

  localparam int EXP_RST = 100 * 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, keepPowerdown = 1'b0, vbusOverride = 1'b0, hostMode = 1'b0;
  logic initReq = 1'b0, suspendReq = 1'b0, resumeReq = 1'b0;
  logic connectEvt = 1'b0, disconnectEvt = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regRdData;
  logic busy, done, phyRst, pcsClkSel, lanePwrPresent, refClkEn, testPowerdown;

  phy_pwr_seq u_dut (
    .clk(clk), .rstN(rstN), .keepPowerdown(keepPowerdown),
    .vbusOverride(vbusOverride), .hostMode(hostMode),
    .initReq(initReq), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .connectEvt(connectEvt), .disconnectEvt(disconnectEvt),
    .regAddr(regAddr), .regRdData(regRdData), .busy(busy), .done(done),
    .phyRst(phyRst), .pcsClkSel(pcsClkSel), .lanePwrPresent(lanePwrPresent),
    .refClkEn(refClkEn), .testPowerdown(testPowerdown)
  );

  int nChecks = 0, nErrors = 0, cyc = 0;
  int riseRst, fallRst, riseClk, riseLane, fallLane, riseRef, fallRef, risePdn, fallPdn;
  int nChanges = 0, nDone = 0, nBusyRise = 0;
  logic pRst, pClk, pLane, pRef, pPdn, pBusy;

  // model of expected state
  logic eRst, eClk, eLane, eRef, ePdn, eSusp;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (phyRst && !pRst) riseRst = cyc;
      if (!phyRst && pRst) fallRst = cyc;
      if (pcsClkSel && !pClk) riseClk = cyc;
      if (lanePwrPresent && !pLane) riseLane = cyc;
      if (!lanePwrPresent && pLane) fallLane = cyc;
      if (refClkEn && !pRef) riseRef = cyc;
      if (!refClkEn && pRef) fallRef = cyc;
      if (testPowerdown && !pPdn) risePdn = cyc;
      if (!testPowerdown && pPdn) fallPdn = cyc;
      nChanges += int'(phyRst != pRst) + int'(pcsClkSel != pClk) + int'(lanePwrPresent != pLane)
                + int'(refClkEn != pRef) + int'(testPowerdown != pPdn);
      if (done) nDone++;
      if (busy && !pBusy) nBusyRise++;
    end
    pRst = phyRst; pClk = pcsClkSel; pLane = lanePwrPresent;
    pRef = refClkEn; pPdn = testPowerdown; pBusy = busy;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expReg(input int a);
    logic [7:0] r;
    r = 8'h00;
    case (a)
      0: r[4] = eClk;
      1: r[7] = eRst;
      2: r[0] = eRef;
      3: begin r[2] = eLane; r[4] = ePdn; end
      4: r[1] = eSusp;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic compareAll(input string req);
    chk({req, " busy"}, int'(busy), 0);
    chk({req, " phyRst"}, int'(phyRst), int'(eRst));
    chk({req, " pcsClkSel"}, int'(pcsClkSel), int'(eClk));
    chk({req, " lanePwr"}, int'(lanePwrPresent), int'(eLane));
    chk({req, " refClkEn"}, int'(refClkEn), int'(eRef));
    chk({req, " testPdn"}, int'(testPowerdown), int'(ePdn));
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a);
      #1;
      chk($sformatf("%s R10 reg%0d", req, a), int'(regRdData), int'(expReg(a)));
    end
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0;
    keepPowerdown = strap;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    eRst = 0; eClk = 0; eLane = 0; eRef = 0; ePdn = strap; eSusp = 1;
  endtask

  // 0 init, 1 suspend, 2 resume, 3 connect, 4 disconnect
  task automatic doReq(input int kind);
    @(negedge clk);
    case (kind)
      0: initReq = 1'b1;
      1: suspendReq = 1'b1;
      2: resumeReq = 1'b1;
      3: connectEvt = 1'b1;
      default: disconnectEvt = 1'b1;
    endcase
    @(negedge clk);
    initReq = 1'b0; suspendReq = 1'b0; resumeReq = 1'b0;
    connectEvt = 1'b0; disconnectEvt = 1'b0;
  endtask

  task automatic waitIdle();
    int streak = 0;
    while (streak < 3) begin
      @(negedge clk);
      streak = busy ? 0 : streak + 1;
    end
  endtask

  // bench model of a request's effect; returns whether activity is expected
  function automatic logic applyModel(input int kind);
    logic ovr;
    ovr = vbusOverride && !hostMode;
    case (kind)
      1: if (!eSusp) begin eRef = 0; ePdn = 1; eSusp = 1; return 1'b1; end
      2: if (eSusp) begin eRef = 1; ePdn = 0; eSusp = 0; return 1'b1; end
      3: if (ovr) begin eLane = 1; return 1'b1; end
      4: if (ovr) begin eLane = 0; return 1'b1; end
      default: return 1'b0;
    endcase
    return 1'b0;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog R8 act=hung exp=idle");
    finishRun();
  end

  initial begin
    int c0, d0, b0, seedv;
    seedv = int'($urandom(32'd20240611));

    // R1 / R12: reset state with strap high
    doReset(1'b1);
    @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R12 strap pdn", int'(testPowerdown), 1);
    compareAll("R1 strap1");

    doReset(1'b0);
    @(negedge clk);
    chk("R12 strap0 pdn", int'(testPowerdown), 0);
    compareAll("R1 strap0");

    // R6: suspend while suspended
    c0 = nChanges; b0 = nBusyRise;
    doReq(1);
    repeat (5) @(negedge clk);
    chk("R6 suspend-idem busy", nBusyRise - b0, 0);
    chk("R6 suspend-idem bits", nChanges - c0, 0);

    // R2 / R3 / R8: init
    d0 = nDone;
    @(negedge clk);
    initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    chk("R8 busy after request", int'(busy), 1);
    waitIdle();
    eRst = 0; eClk = 1; eLane = 1; eRef = 1; eSusp = 0;
    chk("R2 reset min", int'((fallRst - riseRst) >= EXP_RST), 1);
    chk("R2 reset max", int'((fallRst - riseRst) <= EXP_RST + 4), 1);
    chk("R3 clk after rst", int'(riseClk > fallRst), 1);
    chk("R3 lane after clk", int'(riseLane > riseClk), 1);
    chk("R3 ref after lane", int'(riseRef > riseLane), 1);
    chk("R8 one done", nDone - d0, 1);
    compareAll("R3 init");

    // R6: resume while resumed
    c0 = nChanges; b0 = nBusyRise;
    doReq(2);
    repeat (5) @(negedge clk);
    chk("R6 resume-idem busy", nBusyRise - b0, 0);
    chk("R6 resume-idem bits", nChanges - c0, 0);

    // R7: cable events gated by mode
    vbusOverride = 1'b1; hostMode = 1'b1;
    doReq(4); repeat (5) @(negedge clk);
    chk("R7 host blocks disconnect", int'(lanePwrPresent), 1);
    vbusOverride = 1'b0; hostMode = 1'b0;
    doReq(4); repeat (5) @(negedge clk);
    chk("R7 no override blocks", int'(lanePwrPresent), 1);
    vbusOverride = 1'b1;
    doReq(4); waitIdle();
    chk("R7 disconnect clears", int'(lanePwrPresent), 0);
    doReq(3); waitIdle();
    chk("R7 connect sets", int'(lanePwrPresent), 1);

    // R4 / R5: ordering
    doReq(1); waitIdle();
    eRef = 0; ePdn = 1; eSusp = 1;
    chk("R4 ref cleared before pdn", int'(fallRef < risePdn), 1);
    compareAll("R4 suspend");
    doReq(2); waitIdle();
    eRef = 1; ePdn = 0; eSusp = 0;
    chk("R5 ref set before pdn clear", int'(riseRef < fallPdn), 1);
    compareAll("R5 resume");

    // R8 / R11: requests held during init, served by priority
    d0 = nDone;
    doReq(0);
    repeat (3) @(negedge clk);
    doReq(4);
    doReq(1);
    chk("R8 still busy", int'(busy), 1);
    waitIdle();
    eRst = 0; eClk = 1; eLane = 0; eRef = 0; ePdn = 1; eSusp = 1;
    chk("R11 suspend before disconnect", int'(fallRef < fallLane), 1);
    chk("R8 three dones", nDone - d0, 3);
    compareAll("R11 pending");

    // random walk over suspend/resume/connect/disconnect
    for (int it = 0; it < 40; it++) begin
      int kind;
      logic act;
      kind = 1 + int'($urandom % 4);
      vbusOverride = 1'($urandom % 2);
      hostMode = 1'($urandom % 2);
      b0 = nBusyRise;
      act = applyModel(kind);
      doReq(kind);
      waitIdle();
      chk($sformatf("R6 R7 rand%0d activity", it), nBusyRise - b0, int'(act));
      compareAll($sformatf("R9 rand%0d", it));
    end

    finishRun();
  end

endmodule